// File: doc/BRIEF.md
# PHY Management Command Port

This block gives a host one 32-bit register through which it reads and writes registers inside an external Ethernet PHY. A single host write starts a complete management transaction on a two-wire serial bus: a management clock output and a shared data line, split into data out, output enable and data in. Bit 31 of the command selects the direction. Bits 20:16 hold the PHY register number. Bits 15:0 hold the data to write. The PHY's own address on the bus is fixed by a parameter.

The host learns that a transaction has finished by polling bit 31, and its meaning depends on the direction. A write command is issued with bit 31 set, and the block clears it when the frame is over. A read command is issued with bit 31 clear, and the block sets it once bits 15:0 hold the value returned by the PHY. Any command written while a frame is in progress is dropped. Software therefore issues a command, waits, and then polls the flag with a bounded retry count.

Top module: `phy_mgmt_port`

## Requirements
- R1: After reset the register reads 0, the management clock is low and the data output enable is low.
- R2: On a write command (bit 31 = 1), bit 31 reads 1 until the frame ends and then reads 0. Bits 30:0 keep the value that was written.
- R3: On a read command (bit 31 = 0), bit 31 reads 0 until the frame ends and then reads 1. Bits 15:0 then hold the 16 data bits returned by the PHY, and bits 30:16 keep the value that was written.
- R4: Each frame is 64 bit times, sent MSB first: 32 ones, start bits 0 then 1, opcode 0,1 for a write or 1,0 for a read, the 5-bit PHY address parameter, and then command bits 20:16 as the register number.
- R5: A write frame continues with turnaround bits 1,0 and then command bits 15:0, with output enable high for all 64 bit times.
- R6: A read frame releases output enable from the first turnaround bit (bit time 46) to the end of the frame. The data input is sampled on the rising clock edge of bit times 48 to 63, MSB first.
- R7: Each management clock period is CLK_DIV system clocks low followed by CLK_DIV clocks high. The clock idles low, and the data output changes only while the clock is low.
- R8: A command written while a frame is running changes neither the register nor the frame in progress.
- R9: The completion flag changes exactly 128*CLK_DIV system clocks after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the command register |
| host_wdata | input | 32 | Command word: bit 31 flag, bits 20:16 register number, bits 15:0 data |
| host_rdata | output | 32 | Current register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
A bit-position error in the sequencer shows up at once in the captured frame: a field lands in the wrong bit time, or output enable drops at the wrong turnaround slot. Either is visible within one transaction of 64 bit times. A wrong count in the divider changes both the high-time total and the exact cycle on which the flag flips, so the boundary check that samples one cycle before and one cycle at completion catches it. Wrong capture or register update logic leaves a wrong value in bits 15:0 or 30:16 as soon as the flag flips, and a full write-then-read sweep over all 32 registers exposes it.

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port #(
  parameter int CLK_DIV  = 2,
  parameter int PHY_ADDR = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int DW         = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam logic [4:0] PHY_A = PHY_ADDR[4:0];

  logic [31:0]           reg_q;
  logic                  busy, is_rd;
  logic [DW-1:0]         div_cnt;
  logic [5:0]            bit_idx;
  logic [FRAME_BITS-1:0] tx_sr;
  logic [15:0]           rx_sr;
  logic                  tick;
  logic                  wr_cmd;
  logic [FRAME_BITS-1:0] frame;

  assign tick   = busy && (div_cnt == DW'(CLK_DIV - 1));
  assign wr_cmd = host_wdata[31];
  assign frame  = {32'hFFFF_FFFF, 2'b01, wr_cmd ? 2'b01 : 2'b10, PHY_A,
                   host_wdata[20:16], wr_cmd ? 2'b10 : 2'b11,
                   wr_cmd ? host_wdata[15:0] : 16'h0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= '0;
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      mdc     <= 1'b0;
    end else if (!busy) begin
      if (host_wr) begin
        reg_q   <= host_wdata;
        busy    <= 1'b1;
        is_rd   <= ~wr_cmd;
        div_cnt <= '0;
        bit_idx <= '0;
        tx_sr   <= frame;
        mdc     <= 1'b0;
      end
    end else if (!tick) begin
      div_cnt <= div_cnt + 1'b1;
    end else begin
      div_cnt <= '0;
      if (!mdc) begin
        mdc <= 1'b1;
        if (is_rd && bit_idx >= 6'(DATA_POS))
          rx_sr <= {rx_sr[14:0], mdio_i};
      end else begin
        mdc <= 1'b0;
        if (bit_idx == 6'(FRAME_BITS - 1)) begin
          busy      <= 1'b0;
          reg_q[31] <= is_rd;
          if (is_rd) reg_q[15:0] <= rx_sr;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign host_rdata = reg_q;
  assign mdio_o     = busy ? tx_sr[FRAME_BITS-1] : 1'b1;
  assign mdio_oe    = busy && !(is_rd && bit_idx >= 6'(TA_POS));

endmodule

module phy_mgmt_port_chk #(
  parameter int CLK_DIV = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [31:0] host_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o)); // R7

  AST_MDC_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc) && CLK_DIV > 1) |=> mdc); // R7

  AST_WRITE_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_rdata[31]) && !$past(host_wr)) |-> (!mdc && !mdio_oe)); // R2

  AST_READ_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_rdata[31]) && !$past(host_wr)) |-> (!mdc && !mdio_oe)); // R3

  AST_OE_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> !mdc); // R6

  AST_REG_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(host_rdata)); // R8

endmodule

bind phy_mgmt_port phy_mgmt_port_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rdata(host_rdata),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/phy_mgmt_port_tb.sv
module phy_mgmt_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int PHYA       = 11;
  localparam int TXN_CYC    = 128 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  logic        cap_o  [0:63];
  logic        cap_oe [0:63];
  int          rise_cnt = 0;
  logic [15:0] phy_mem [0:31];
  int          hi_cnt = 0;
  logic        meas = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_port #(.CLK_DIV(DIV), .PHY_ADDR(PHYA)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap_o[rise_cnt]  = mdio_o;
      cap_oe[rise_cnt] = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    if (rise_cnt >= 46) begin
      logic [4:0] ra;
      ra = {cap_o[41], cap_o[42], cap_o[43], cap_o[44], cap_o[45]};
      if (cap_o[34] && !cap_o[35] && rise_cnt >= 48 && rise_cnt <= 63)
        mdio_i = phy_mem[ra][63 - rise_cnt];
      else
        mdio_i = 1'b1;
      if (rise_cnt == 64 && !cap_o[34] && cap_o[35])
        for (int k = 0; k < 16; k++) phy_mem[ra][15 - k] = cap_o[48 + k];
    end
  end

  always @(negedge clk) if (meas) hi_cnt = hi_cnt + (mdc ? 1 : 0);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    logic [15:0] v;
    v = (16'h8000 >> (a % 16)) ^ 16'(a * 16'h0123);
    if (a >= 16) v = ~v;
    return v;
  endfunction

  task automatic run_cmd(input logic [31:0] cmd, input bit inject);
    logic [31:0] exp_reg;
    logic [63:0] exp_frame, got;
    logic [4:0]  ra;
    bit          wr;
    wr = cmd[31];
    ra = cmd[20:16];
    rise_cnt = 0;
    hi_cnt = 0;
    @(negedge clk);
    host_wr = 1'b1; host_wdata = cmd; meas = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    repeat (10) @(negedge clk);
    if (inject) begin host_wr = 1'b1; host_wdata = ~cmd; end
    @(negedge clk);
    host_wr = 1'b0;
    check(host_rdata == cmd, "R8 reg untouched by write during frame", 64'(host_rdata), 64'(cmd));
    repeat (TXN_CYC - 1 - 11) @(negedge clk);
    check(host_rdata[31] == wr, wr ? "R2 flag set before end" : "R3 flag clear before end",
          64'(host_rdata[31]), 64'(wr));
    check(host_rdata == cmd, "R9 reg unchanged one cycle before end", 64'(host_rdata), 64'(cmd));
    @(negedge clk);
    meas = 1'b0;
    exp_reg = wr ? {1'b0, cmd[30:0]} : {1'b1, cmd[30:16], pat(int'(ra))};
    check(host_rdata == exp_reg, wr ? "R2 R9 write completion" : "R3 R9 read completion",
          64'(host_rdata), 64'(exp_reg));
    check(!mdc && !mdio_oe, "R7 bus idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    check(hi_cnt == 64 * DIV, "R7 mdc high time", 64'(hi_cnt), 64'(64 * DIV));
    check(rise_cnt == 64, "R4 frame bit count", 64'(rise_cnt), 64'd64);
    exp_frame = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, 5'(PHYA), ra,
                 2'b10, cmd[15:0]};
    for (int k = 0; k < 64; k++) got[63 - k] = cap_o[k];
    if (wr)
      check(got == exp_frame, "R4 R5 write frame bits", got, exp_frame);
    else
      check(got[63:18] == exp_frame[63:18], "R4 read frame header bits",
            64'(got[63:18]), 64'(exp_frame[63:18]));
    for (int k = 0; k < 64; k++) got[63 - k] = cap_oe[k];
    exp_frame = wr ? '1 : {{46{1'b1}}, 18'd0};
    check(got == exp_frame, wr ? "R5 write output enable" : "R6 read output enable",
          got, exp_frame);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    check(host_rdata == 32'd0, "R1 reset register", 64'(host_rdata), 64'd0);
    check(!mdc && !mdio_oe, "R1 reset bus", {62'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(host_rdata == 32'd0 && !mdc, "R1 idle after reset", 64'(host_rdata), 64'd0);
    for (int a = 0; a < 32; a++)
      run_cmd({1'b1, 10'(a * 37), 5'(a), pat(a)}, (a % 4) == 1);
    for (int a = 0; a < 32; a++)
      run_cmd({1'b0, 10'(a * 91 + 5), 5'(a), 16'(a * 16'h0F0F)}, (a % 4) == 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule